// File: doc/BRIEF.md
# Flag and Bit Transfer Unit

This unit executes the single-bit instructions of an 8-bit microcontroller core. Each cycle it decodes one 16-bit instruction word. It can force one status flag high or low. It can copy a chosen bit of a register operand into the T flag, or write T into a chosen bit of that operand. It can also test a register bit and ask the program-counter logic to skip the following instruction.

The register operand arrives already read from the register file. The register file takes the target register address from the instruction's own 5-bit field at [8:4]. The unit returns three things:
- the updated register value with a write enable;
- the next status byte;
- a skip request.

All outputs are registered, one clock after the instruction is presented. Words that do not belong to this group pass the status through unchanged. They cause no write and no skip.

Top module: `flagbit_unit`

## Requirements
- R1: While reset is high, and on the first clock edge after it, regOut, regWe, statusOut and skipReq are all zero.
- R2: A word of the form 1001_0100_0sss_1000 sets status bit sss and leaves the other seven status bits unchanged. The bit positions are C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7.
- R3: A word of the form 1001_0100_1sss_1000 clears status bit sss and leaves the other status bits unchanged.
- R4: A word of the form 1111_101d_dddd_0bbb copies register-operand bit bbb into status bit 6 (T). It changes no other status bit and does not write the register.
- R5: A word of the form 1111_100d_dddd_0bbb asserts regWe. regOut equals the operand with bit bbb replaced by status bit 6, and the status is passed through unchanged.
- R6: A word of the form 1111_110d_dddd_0bbb asserts skipReq exactly when operand bit bbb is 0.
- R7: A word of the form 1111_111d_dddd_0bbb asserts skipReq exactly when operand bit bbb is 1. Word bit 9 is the required value.
- R8: The bit-test words never assert regWe and never change the status. skipReq is high for one cycle per qualifying instruction cycle and low otherwise.
- R9: Any other word, including the forms above with a wrong bit 3 or wrong low nibble, leaves regWe and skipReq low and passes the status through.
- R10: Every output reflects the inputs of the previous clock cycle, and regOut equals the operand whenever regWe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 16 | Instruction word |
| regIn | input | 8 | Register operand selected by instr[8:4] |
| statusIn | input | 8 | Current status byte |
| regOut | output | 8 | Register value to write back |
| regWe | output | 1 | Register write enable |
| statusOut | output | 8 | Next status byte |
| skipReq | output | 1 | Request to skip the next instruction |

## Verification
The assertions assume that the status byte and operand seen one cycle earlier are the ones the outputs should be compared with. They therefore only arm after one clock out of reset. They also assume that the register operand belongs to the same instruction word, so the write-back and bit-test checks can compare regOut with the previous regIn. The stimulus drives all three inputs together, once per cycle, on the falling edge. In the chained flag sequences it feeds the model's last expected status back as the next status input, so the inputs always form a consistent instruction stream.

// File: rtl/flagbit_pkg.sv
package flagbit_pkg;
  localparam int DATA_W  = 8;
  localparam int INSTR_W = 16;
  localparam int IDX_W   = $clog2(DATA_W);

  typedef struct packed {
    logic             setFlag;
    logic             clrFlag;
    logic             bitStore;
    logic             bitLoad;
    logic             bitTest;
    logic             needOne;
    logic [IDX_W-1:0] flagSel;
    logic [IDX_W-1:0] bitSel;
  } strobe_t;
endpackage

// File: rtl/flagbit_decode.sv
module flagbit_decode
  import flagbit_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output strobe_t            stb
);
  logic isFlagOp;
  logic lowOk;

  always_comb begin
    isFlagOp    = (instr[15:8] == 8'b1001_0100) && (instr[3:0] == 4'b1000);
    lowOk       = (instr[3] == 1'b0);
    stb.setFlag = isFlagOp && !instr[7];
    stb.clrFlag = isFlagOp && instr[7];
    stb.bitStore = (instr[15:9] == 7'b1111101) && lowOk;
    stb.bitLoad  = (instr[15:9] == 7'b1111100) && lowOk;
    stb.bitTest  = (instr[15:10] == 6'b111111) && lowOk;
    stb.needOne  = instr[9];
    stb.flagSel  = instr[6:4];
    stb.bitSel   = instr[2:0];
  end
endmodule

// File: rtl/flagbit_datapath.sv
module flagbit_datapath
  import flagbit_pkg::*;
#(
  parameter int T_POS = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] regIn,
  input  logic [DATA_W-1:0] statusIn,
  output logic [DATA_W-1:0] regOut,
  output logic              regWe,
  output logic [DATA_W-1:0] statusOut,
  output logic              skipReq
);
  logic [DATA_W-1:0] flagMask;
  logic [DATA_W-1:0] bitMask;
  logic [DATA_W-1:0] nextStatus;
  logic [DATA_W-1:0] nextReg;
  logic              pickedBit;
  logic              tFlag;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign flagMask[i] = (stb.flagSel == IDX_W'(i));
    assign bitMask[i]  = (stb.bitSel == IDX_W'(i));
  end

  always_comb begin
    pickedBit  = |(regIn & bitMask);
    tFlag      = statusIn[T_POS];
    nextStatus = statusIn;
    nextReg    = regIn;
    if (stb.setFlag) nextStatus = statusIn | flagMask;
    if (stb.clrFlag) nextStatus = statusIn & ~flagMask;
    if (stb.bitStore) nextStatus[T_POS] = pickedBit;
    if (stb.bitLoad) nextReg = (regIn & ~bitMask) | (tFlag ? bitMask : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      regOut    <= '0;
      regWe     <= 1'b0;
      statusOut <= '0;
      skipReq   <= 1'b0;
    end else begin
      regOut    <= nextReg;
      regWe     <= stb.bitLoad;
      statusOut <= nextStatus;
      skipReq   <= stb.bitTest && (pickedBit == stb.needOne);
    end
  end
endmodule

// File: rtl/flagbit_unit.sv
module flagbit_unit
  import flagbit_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0]  regIn,
  input  logic [DATA_W-1:0]  statusIn,
  output logic [DATA_W-1:0]  regOut,
  output logic               regWe,
  output logic [DATA_W-1:0]  statusOut,
  output logic               skipReq
);
  strobe_t stb;

  flagbit_decode u_decode (
    .instr (instr),
    .stb   (stb)
  );

  flagbit_datapath #(.T_POS(6)) u_path (
    .clk       (clk),
    .rst       (rst),
    .stb       (stb),
    .regIn     (regIn),
    .statusIn  (statusIn),
    .regOut    (regOut),
    .regWe     (regWe),
    .statusOut (statusOut),
    .skipReq   (skipReq)
  );
endmodule

// File: rtl/flagbit_chk.sv
module flagbit_chk
  import flagbit_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic [INSTR_W-1:0] instr,
  input logic [DATA_W-1:0]  regIn,
  input logic [DATA_W-1:0]  statusIn,
  input logic [DATA_W-1:0]  regOut,
  input logic               regWe,
  input logic [DATA_W-1:0]  statusOut,
  input logic               skipReq
);
  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  // R2, R3, R4: no instruction changes more than one status bit
  p_single_status_bit_r2: assert property (@(posedge clk) disable iff (rst)
    armed |-> ($countones(statusOut ^ $past(statusIn)) <= 1));

  // R8: a skip request never comes with a register write
  p_test_no_write_r8: assert property (@(posedge clk) disable iff (rst)
    skipReq |-> !regWe);

  // R8: a skip request leaves the status untouched
  p_test_status_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (armed && skipReq) |-> (statusOut == $past(statusIn)));

  // R5: a write back differs from the operand in at most one bit
  p_reg_single_bit_r5: assert property (@(posedge clk) disable iff (rst)
    (armed && regWe) |-> ($countones(regOut ^ $past(regIn)) <= 1));

  // R5: a bit load passes the status through
  p_load_status_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (armed && regWe) |-> (statusOut == $past(statusIn)));

  // R10: without a write the operand is returned unchanged
  p_reg_pass_r10: assert property (@(posedge clk) disable iff (rst)
    (armed && !regWe) |-> (regOut == $past(regIn)));
endmodule

bind flagbit_unit flagbit_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .instr     (instr),
  .regIn     (regIn),
  .statusIn  (statusIn),
  .regOut    (regOut),
  .regWe     (regWe),
  .statusOut (statusOut),
  .skipReq   (skipReq)
);

// File: tb/tb_flagbit_unit.sv
module tb_flagbit_unit;
  logic        clk = 0;
  logic        rst = 1;
  logic [15:0] instr = 0;
  logic [7:0]  regIn = 0;
  logic [7:0]  statusIn = 0;
  logic [7:0]  regOut;
  logic        regWe;
  logic [7:0]  statusOut;
  logic        skipReq;

  int  total = 0;
  int  bad = 0;
  bit  done = 0;
  logic [7:0] lastStatus;

  always #5 clk = ~clk;

  flagbit_unit dut (
    .clk(clk), .rst(rst), .instr(instr), .regIn(regIn), .statusIn(statusIn),
    .regOut(regOut), .regWe(regWe), .statusOut(statusOut), .skipReq(skipReq)
  );

  // Behavioural reference: computes expected outputs for one instruction
  task automatic refModel(input logic [15:0] w, input logic [7:0] r, input logic [7:0] s,
                          output logic [7:0] eR, output logic eW,
                          output logic [7:0] eS, output logic eK);
    int op  = w >> 9;
    int pos = w & 7;
    int bitV = (r >> pos) & 1;
    int tV = (s >> 6) & 1;
    eR = r; eW = 0; eS = s; eK = 0;
    if ((w >> 8) == 'h94 && (w & 'hF) == 8) begin
      int f = (w >> 4) & 7;
      if (((w >> 7) & 1) == 0) eS = s | (8'd1 << f);
      else eS = s & ~(8'd1 << f);
    end else if (((w >> 3) & 1) == 0) begin
      if (op == 'h7D) eS = tV ? (s & 8'hBF) | (bitV[0] ? 8'h40 : 8'h00)
                              : (s & 8'hBF) | (bitV[0] ? 8'h40 : 8'h00);
      else if (op == 'h7C) begin
        eW = 1;
        eR = tV[0] ? (r | (8'd1 << pos)) : (r & ~(8'd1 << pos));
      end else if (op == 'h7E) eK = (bitV == 0);
      else if (op == 'h7F) eK = (bitV == 1);
    end
  endtask

  task automatic check(input string tag, input logic [7:0] eR, input logic eW,
                       input logic [7:0] eS, input logic eK);
    total++;
    if (regOut !== eR || regWe !== eW || statusOut !== eS || skipReq !== eK) begin
      bad++;
      $display("FAIL %s: got reg=%h we=%b st=%h skip=%b exp reg=%h we=%b st=%h skip=%b",
               tag, regOut, regWe, statusOut, skipReq, eR, eW, eS, eK);
    end
  endtask

  // Drive one instruction at the falling edge, compare one cycle later
  task automatic apply(input string tag, input logic [15:0] w, input logic [7:0] r,
                       input logic [7:0] s);
    logic [7:0] eR, eS;
    logic eW, eK;
    instr = w; regIn = r; statusIn = s;
    refModel(w, r, s, eR, eW, eS, eK);
    @(negedge clk);
    check(tag, eR, eW, eS, eK);
    lastStatus = eS;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hung exp finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    instr = 16'hF9F0; regIn = 8'hFF; statusIn = 8'hFF;
    repeat (3) @(negedge clk);
    check("R1 reset", 8'h00, 1'b0, 8'h00, 1'b0);
    rst = 0;
    instr = 16'h0000; regIn = 8'h00; statusIn = 8'h00;
    @(negedge clk);
    check("R1 first cycle", 8'h00, 1'b0, 8'h00, 1'b0);

    // R2/R3 chained: set I, set C, clear I
    apply("R2 set I", 16'h9478, 8'h00, 8'h00);
    check("R2 set I value", 8'h00, 0, 8'h80, 0);
    apply("R2 set C", 16'h9408, 8'h00, lastStatus);
    check("R2 status 0x81", 8'h00, 0, 8'h81, 0);
    apply("R3 clear I", 16'h94F8, 8'h00, lastStatus);
    check("R3 status 0x01", 8'h00, 0, 8'h01, 0);

    for (int k = 0; k < 8; k++) begin
      apply("R2 set each flag", 16'h9408 | 16'(k << 4), 8'h5A, 8'h00);
      apply("R3 clear each flag", 16'h9488 | 16'(k << 4), 8'hA5, 8'hFF);
      apply("R2 set on mixed", 16'h9408 | 16'(k << 4), 8'h00, 8'h3C);
    end

    // R4 bit store, R5 bit load
    apply("R4 store bit4", 16'hFBF4, 8'h10, 8'h00);
    check("R4 T set", 8'h10, 0, 8'h40, 0);
    apply("R5 load bit0 T=1", 16'hF9F0, 8'h10, 8'h40);
    check("R5 gives 0x11", 8'h11, 1, 8'h40, 0);
    apply("R5 load bit4 T=0", 16'hF9F4, 8'h11, 8'h00);
    check("R5 gives 0x01", 8'h01, 1, 8'h00, 0);
    apply("R4 store zero", 16'hFBF4, 8'h00, 8'hFF);
    check("R4 T cleared", 8'h00, 0, 8'hBF, 0);

    // R6/R7 bit test skip
    apply("R7 set test hit", 16'hFF43, 8'h08, 8'h00);
    apply("R7 set test miss", 16'hFF42, 8'h08, 8'h00);
    apply("R6 clear test miss", 16'hFD43, 8'h08, 8'h00);
    apply("R6 clear test hit", 16'hFD43, 8'h00, 8'h00);
    apply("R8 held test hit", 16'hFD43, 8'h00, 8'h7E);
    apply("R8 pulse ends", 16'h0000, 8'h00, 8'h7E);
    check("R8 low after", 8'h00, 0, 8'h7E, 0);

    // R9 unrelated or malformed words
    apply("R9 zero word", 16'h0000, 8'hC3, 8'h55);
    apply("R9 bad low nibble", 16'h9409, 8'hC3, 8'h55);
    apply("R9 store bit3 set", 16'hFBF8, 8'hFF, 8'h00);
    apply("R9 test bit3 set", 16'hFF48, 8'hFF, 8'h00);
    apply("R9 load bit3 set", 16'hF9F8, 8'h00, 8'h40);

    // R10 mixed stream, one result per cycle
    for (int n = 0; n < 400; n++) begin
      logic [15:0] w = 16'($urandom);
      case (n % 5)
        0: w = (w & 16'h00F7) | 16'h9408 & 16'hFF8F | (w & 16'h00F0) & 16'h00F0;
        1: w = (w & 16'h01F7) | 16'hFA00;
        2: w = (w & 16'h01F7) | 16'hF800;
        3: w = (w & 16'h03F7) | 16'hFC00;
        default: ;
      endcase
      if (n % 5 == 0) w = 16'h9408 | (w & 16'h00F0);
      apply("R10 random stream", w, 8'($urandom), 8'($urandom));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule